// File: doc/BRIEF.md
# Leaf Page-Entry Access Judge

This purely combinational block decides, for one leaf entry of a page table, what a memory access to that page may do. It receives the eight attribute bits of the entry, the kind of access (load, store, atomic read-modify-write, instruction fetch), the privilege level of the requester, and two status flags. The first flag makes execute-only pages readable. The second lets supervisor loads and stores touch user pages. From these it reports whether the entry is malformed, whether it points to a further table level, whether the access is allowed, and whether the accessed/dirty bits must be written back. When they must, it also gives the new attribute byte.

A second, independent path turns a page-walk failure kind and the access kind into a 4-bit exception cause code. The walker around this block uses that code to raise the trap. No state is held. Every output follows the inputs within the same cycle.

Top module: `pte_judge`

## Requirements
- R1: The attribute byte is decoded by bit position, bit 7 down to bit 0: dirty, accessed, global, user, execute, write, read, valid.
- R2: `invalid_o` is high when the valid bit is clear, or when the write bit is set while the read bit is clear.
- R3: `pointer_o` is high exactly when the read, write and execute bits are all clear, whatever the valid bit.
- R4: Access kind encoding is 0 load, 1 store, 2 read-modify-write, 3 fetch. For privilege 0 (user), `grant_o` requires the user bit set. A load also needs read set, or execute set with `mxr_i` high. A store needs write set. A read-modify-write needs both the store and the load rule. A fetch needs execute set.
- R5: For privilege 1 (supervisor), a load, store or read-modify-write requires the user bit clear or `sum_i` high, plus the same read/write/execute rules as R4.
- R6: A supervisor fetch is granted only when the user bit is clear and execute is set, regardless of `sum_i`.
- R7: Privilege code 3 is machine mode and code 2 is reserved. For either, `priv_err_o` is high and `grant_o` is low. For codes 0 and 1, `priv_err_o` is low.
- R8: `upd_need_o` is high when the accessed bit is clear, or when the access is a store or read-modify-write and the dirty bit is clear. `upd_attr_o` is then the input byte with accessed set, and with dirty also set for store/read-modify-write. When no update is needed, `upd_attr_o` equals the input byte.
- R9: Failure kind encoding is 0 bus/access error, 1 malformed entry, 2 permission denied, 3 misaligned superpage, 4 update needed but disabled. Kind 0 gives cause 1 for fetch, 5 for load, and 7 for store or read-modify-write.
- R10: Any nonzero failure kind gives a page-fault cause: 12 for fetch, 13 for load, and 15 for store or read-modify-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| attr_i | input | 8 | Attribute byte of the leaf entry |
| acc_i | input | 2 | Access kind |
| priv_i | input | 2 | Requester privilege level |
| mxr_i | input | 1 | Execute-only pages readable |
| sum_i | input | 1 | Supervisor may load/store user pages |
| fail_i | input | 3 | Page-walk failure kind |
| invalid_o | output | 1 | Entry is malformed |
| pointer_o | output | 1 | Entry points to next table level |
| grant_o | output | 1 | Access permitted |
| priv_err_o | output | 1 | Privilege level not handled here |
| upd_need_o | output | 1 | Accessed/dirty write-back required |
| upd_attr_o | output | 8 | Attribute byte after the update |
| cause_o | output | 4 | Exception cause code |

## Verification
The block holds no state, so a wrong internal signal appears on the affected output in the very cycle its inputs are applied. It stays visible for as long as those inputs are held. A mis-gated user or sum term shows up as a wrong `grant_o` only for particular privilege and access pairs. The stimulus therefore mixes random vectors with directed cases on the sum, mxr and fetch corners. A wrong dirty/accessed choice appears as a wrong `upd_attr_o` byte. That byte is compared in full, so bits that must pass through unchanged are also covered.

// File: rtl/pte_judge_pkg.sv
package pte_judge_pkg;

    localparam int ATTR_W  = 8;
    localparam int CAUSE_W = 4;
    localparam int FAIL_W  = 3;
    localparam int ACC_W   = 2;
    localparam int PRV_W   = 2;

    typedef struct packed {
        logic dirty;
        logic accessed;
        logic glob;
        logic usr;
        logic exe;
        logic wr;
        logic rd;
        logic vld;
    } attr_t;

    typedef enum logic [ACC_W-1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_RMW   = 2'd2,
        ACC_FETCH = 2'd3
    } acc_e;

    typedef enum logic [PRV_W-1:0] {
        PRV_USER  = 2'd0,
        PRV_SUPER = 2'd1,
        PRV_RSVD  = 2'd2,
        PRV_MACH  = 2'd3
    } prv_e;

    localparam logic [FAIL_W-1:0] FLT_BUS       = 3'd0;
    localparam logic [FAIL_W-1:0] FLT_BAD_ENTRY = 3'd1;
    localparam logic [FAIL_W-1:0] FLT_DENIED    = 3'd2;
    localparam logic [FAIL_W-1:0] FLT_MISALIGN  = 3'd3;
    localparam logic [FAIL_W-1:0] FLT_NO_UPDATE = 3'd4;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_ACC  = 4'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD_ACC   = 4'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE_ACC  = 4'd7;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_PAGE = 4'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD_PAGE  = 4'd13;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE_PAGE = 4'd15;

    // store-class accesses write memory and therefore dirty the page
    function automatic logic writes_mem(input acc_e a);
        return (a == ACC_STORE) || (a == ACC_RMW);
    endfunction

    function automatic logic priv_handled(input prv_e p);
        return (p == PRV_USER) || (p == PRV_SUPER);
    endfunction

endpackage

// File: rtl/pte_decode.sv
module pte_decode (
    input  logic vld_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic exe_i,
    output logic invalid_o,
    output logic pointer_o
);

    always_comb begin
        invalid_o = !vld_i || (wr_i && !rd_i);
        pointer_o = !rd_i && !wr_i && !exe_i;
    end

    // R2: a valid pointer entry can never be malformed; clear valid always is
    always_comb begin
        a_r2_valid_ptr_ok: assert (!(pointer_o && vld_i) || !invalid_o)
            else $error("a_r2_valid_ptr_ok");
        a_r2_clear_valid: assert (vld_i || invalid_o)
            else $error("a_r2_clear_valid");
    end

endmodule

// File: rtl/pte_perm_chk.sv
module pte_perm_chk
    import pte_judge_pkg::*;
(
    input  acc_e acc_i,
    input  prv_e prv_i,
    input  logic mxr_i,
    input  logic sum_i,
    input  logic usr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic exe_i,
    output logic grant_o,
    output logic priv_err_o
);

    logic rd_ok;
    logic rwx_ok;
    logic page_ok;

    always_comb begin
        rd_ok  = rd_i || (exe_i && mxr_i);
        rwx_ok = 1'b0;
        case (acc_i)
            ACC_LOAD:  rwx_ok = rd_ok;
            ACC_STORE: rwx_ok = wr_i;
            ACC_RMW:   rwx_ok = wr_i && rd_ok;
            ACC_FETCH: rwx_ok = exe_i;
            default:   rwx_ok = 1'b0;
        endcase
    end

    // ownership gate: user pages vs supervisor pages
    always_comb begin
        page_ok = 1'b0;
        case (prv_i)
            PRV_USER:  page_ok = usr_i;
            PRV_SUPER: page_ok = (acc_i == ACC_FETCH) ? !usr_i : (!usr_i || sum_i);
            default:   page_ok = 1'b0;
        endcase
    end

    always_comb begin
        priv_err_o = !priv_handled(prv_i);
        grant_o    = !priv_err_o && rwx_ok && page_ok;
    end

    always_comb begin
        // R4: user grant implies user page
        a_r4_user_page: assert (!(prv_i == PRV_USER && grant_o) || usr_i)
            else $error("a_r4_user_page");
        // R5: supervisor data access to a user page needs sum
        a_r5_super_sum: assert (!(prv_i == PRV_SUPER && acc_i != ACC_FETCH && grant_o && usr_i) || sum_i)
            else $error("a_r5_super_sum");
        // R6: supervisor fetch only from executable supervisor pages
        a_r6_super_fetch: assert (!(prv_i == PRV_SUPER && acc_i == ACC_FETCH && grant_o) || (!usr_i && exe_i))
            else $error("a_r6_super_fetch");
        // R7: unhandled privilege never grants
        a_r7_no_grant: assert (!priv_err_o || !grant_o)
            else $error("a_r7_no_grant");
    end

endmodule

// File: rtl/pte_ad_update.sv
module pte_ad_update
    import pte_judge_pkg::*;
(
    input  attr_t cur_i,
    input  acc_e  acc_i,
    output logic  need_o,
    output attr_t nxt_o
);

    logic set_a;
    logic set_d;

    always_comb begin
        set_d  = writes_mem(acc_i) && !cur_i.dirty;
        set_a  = !cur_i.accessed;
        need_o = set_a || set_d;
        nxt_o  = cur_i;
        if (need_o) begin
            nxt_o.accessed = 1'b1;
            if (set_d) begin
                nxt_o.dirty = 1'b1;
            end
        end
    end

    always_comb begin
        // R8: untouched byte when nothing to update
        a_r8_pass_through: assert (need_o || nxt_o == cur_i)
            else $error("a_r8_pass_through");
        // R8: any update marks the page accessed
        a_r8_sets_accessed: assert (!need_o || nxt_o.accessed)
            else $error("a_r8_sets_accessed");
        // R8: loads and fetches never change dirty
        a_r8_load_keeps_d: assert (writes_mem(acc_i) || nxt_o.dirty == cur_i.dirty)
            else $error("a_r8_load_keeps_d");
    end

endmodule

// File: rtl/pte_fault_map.sv
module pte_fault_map
    import pte_judge_pkg::*;
(
    input  acc_e                acc_i,
    input  logic [FAIL_W-1:0]   fail_i,
    output logic [CAUSE_W-1:0]  cause_o
);

    logic bus_err;

    always_comb begin
        bus_err = (fail_i == FLT_BUS);
        case (acc_i)
            ACC_FETCH: cause_o = bus_err ? CAUSE_FETCH_ACC : CAUSE_FETCH_PAGE;
            ACC_LOAD:  cause_o = bus_err ? CAUSE_LOAD_ACC  : CAUSE_LOAD_PAGE;
            default:   cause_o = bus_err ? CAUSE_STORE_ACC : CAUSE_STORE_PAGE;
        endcase
    end

    always_comb begin
        // R9: bus errors map only to access-fault causes
        a_r9_access_cause: assert (!bus_err || cause_o == CAUSE_FETCH_ACC ||
                                   cause_o == CAUSE_LOAD_ACC || cause_o == CAUSE_STORE_ACC)
            else $error("a_r9_access_cause");
        // R10: other kinds map to page-fault causes
        a_r10_page_cause: assert (bus_err || cause_o >= CAUSE_FETCH_PAGE)
            else $error("a_r10_page_cause");
    end

endmodule

// File: rtl/pte_judge.sv
module pte_judge
    import pte_judge_pkg::*;
(
    input  logic [ATTR_W-1:0]  attr_i,
    input  logic [ACC_W-1:0]   acc_i,
    input  logic [PRV_W-1:0]   priv_i,
    input  logic               mxr_i,
    input  logic               sum_i,
    input  logic [FAIL_W-1:0]  fail_i,
    output logic               invalid_o,
    output logic               pointer_o,
    output logic               grant_o,
    output logic               priv_err_o,
    output logic               upd_need_o,
    output logic [ATTR_W-1:0]  upd_attr_o,
    output logic [CAUSE_W-1:0] cause_o
);

    attr_t attr;
    attr_t nxt_attr;
    acc_e  acc;
    prv_e  prv;

    always_comb begin
        attr = attr_t'(attr_i);
        acc  = acc_e'(acc_i);
        prv  = prv_e'(priv_i);
    end

    pte_decode u_decode (
        .vld_i     (attr.vld),
        .rd_i      (attr.rd),
        .wr_i      (attr.wr),
        .exe_i     (attr.exe),
        .invalid_o (invalid_o),
        .pointer_o (pointer_o)
    );

    pte_perm_chk u_perm (
        .acc_i      (acc),
        .prv_i      (prv),
        .mxr_i      (mxr_i),
        .sum_i      (sum_i),
        .usr_i      (attr.usr),
        .rd_i       (attr.rd),
        .wr_i       (attr.wr),
        .exe_i      (attr.exe),
        .grant_o    (grant_o),
        .priv_err_o (priv_err_o)
    );

    pte_ad_update u_update (
        .cur_i  (attr),
        .acc_i  (acc),
        .need_o (upd_need_o),
        .nxt_o  (nxt_attr)
    );

    pte_fault_map u_fault (
        .acc_i   (acc),
        .fail_i  (fail_i),
        .cause_o (cause_o)
    );

    assign upd_attr_o = nxt_attr;

    // R1: global bit is carried unchanged through the update path
    always_comb begin
        a_r1_glob_kept: assert (upd_attr_o[5] == attr_i[5])
            else $error("a_r1_glob_kept");
    end

endmodule

// File: tb/test_pte_judge.sv
module test_pte_judge;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] attr_i = '0;
    logic [1:0] acc_i = '0;
    logic [1:0] priv_i = '0;
    logic       mxr_i = 1'b0;
    logic       sum_i = 1'b0;
    logic [2:0] fail_i = '0;
    logic       invalid_o, pointer_o, grant_o, priv_err_o, upd_need_o;
    logic [7:0] upd_attr_o;
    logic [3:0] cause_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;  // 50 MHz

    pte_judge i_pte_judge (
        .attr_i     (attr_i),
        .acc_i      (acc_i),
        .priv_i     (priv_i),
        .mxr_i      (mxr_i),
        .sum_i      (sum_i),
        .fail_i     (fail_i),
        .invalid_o  (invalid_o),
        .pointer_o  (pointer_o),
        .grant_o    (grant_o),
        .priv_err_o (priv_err_o),
        .upd_need_o (upd_need_o),
        .upd_attr_o (upd_attr_o),
        .cause_o    (cause_o)
    );

    // model, bit positions per R1: 7 D, 6 A, 4 U, 3 X, 2 W, 1 R, 0 V
    function automatic logic m_grant(input logic [7:0] a, input logic [1:0] ac,
                                     input logic [1:0] pv, input logic m, input logic s);
        logic rdok, base;
        rdok = a[1] | (a[3] & m);
        case (ac)
            2'd0: base = rdok;
            2'd1: base = a[2];
            2'd2: base = a[2] & rdok;
            default: base = a[3];
        endcase
        if (pv == 2'd0) return a[4] & base;
        if (pv == 2'd1) begin
            if (ac == 2'd3) return !a[4] & a[3];
            return (!a[4] | s) & base;
        end
        return 1'b0;
    endfunction

    function automatic logic [7:0] m_upd(input logic [7:0] a, input logic [1:0] ac);
        logic [7:0] r;
        r = a;
        if (!a[6] || ((ac == 2'd1 || ac == 2'd2) && !a[7])) begin
            r[6] = 1'b1;
            if (ac == 2'd1 || ac == 2'd2) r[7] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [3:0] m_cause(input logic [1:0] ac, input logic [2:0] f);
        if (f == 3'd0) return (ac == 2'd3) ? 4'd1 : (ac == 2'd0) ? 4'd5 : 4'd7;
        return (ac == 2'd3) ? 4'd12 : (ac == 2'd0) ? 4'd13 : 4'd15;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (attr=%h acc=%0d priv=%0d mxr=%0d sum=%0d fail=%0d)",
                     req, what, act, exp, attr_i, acc_i, priv_i, mxr_i, sum_i, fail_i);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [1:0] ac, input logic [1:0] pv,
                         input logic m, input logic s, input logic [2:0] f);
        @(posedge clk);
        attr_i = a; acc_i = ac; priv_i = pv; mxr_i = m; sum_i = s; fail_i = f;
        @(negedge clk);
    endtask

    task automatic check_all();
        string gtag;
        logic [7:0] eu;
        if (priv_i > 2'd1)       gtag = "R7";
        else if (priv_i == 2'd0) gtag = "R4";
        else if (acc_i == 2'd3)  gtag = "R6";
        else                     gtag = "R5";
        eu = m_upd(attr_i, acc_i);
        chk("R2", "invalid", int'(invalid_o), int'(!attr_i[0] | (attr_i[2] & !attr_i[1])));
        chk("R3", "pointer", int'(pointer_o), int'(attr_i[3:1] == 3'b000));
        chk(gtag, "grant", int'(grant_o), int'(m_grant(attr_i, acc_i, priv_i, mxr_i, sum_i)));
        chk("R7", "priv_err", int'(priv_err_o), int'(priv_i > 2'd1));
        chk("R8", "upd_need", int'(upd_need_o), int'(eu != attr_i));
        chk("R8", "upd_attr", int'(upd_attr_o), int'(eu));
        chk(fail_i == 3'd0 ? "R9" : "R10", "cause", int'(cause_o), int'(m_cause(acc_i, fail_i)));
    endtask

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: all inputs zero
        chk("R2", "reset invalid", int'(invalid_o), 1);
        chk("R8", "reset upd_attr", int'(upd_attr_o), 8'h40);
        chk("R9", "reset cause", int'(cause_o), 5);
        check_all();

        // R1: read+valid+user page, user load granted
        apply(8'h13, 2'd0, 2'd0, 1'b0, 1'b0, 3'd0);
        chk("R1", "user load R page", int'(grant_o), 1);
        check_all();
        // R4: execute-only page readable only with mxr
        apply(8'h19, 2'd0, 2'd0, 1'b0, 1'b0, 3'd1);
        chk("R4", "xonly no mxr", int'(grant_o), 0);
        check_all();
        apply(8'h19, 2'd0, 2'd0, 1'b1, 1'b0, 3'd1);
        chk("R4", "xonly mxr", int'(grant_o), 1);
        check_all();
        // R6: supervisor fetch from user page denied even with sum
        apply(8'h19, 2'd3, 2'd1, 1'b0, 1'b1, 3'd2);
        chk("R6", "sfetch user", int'(grant_o), 0);
        check_all();
        apply(8'h09, 2'd3, 2'd1, 1'b0, 1'b0, 3'd0);
        chk("R6", "sfetch super", int'(grant_o), 1);
        check_all();
        // R5: supervisor store to user page depends on sum
        apply(8'h17, 2'd1, 2'd1, 1'b0, 1'b0, 3'd0);
        chk("R5", "sstore no sum", int'(grant_o), 0);
        check_all();
        apply(8'h17, 2'd1, 2'd1, 1'b0, 1'b1, 3'd0);
        chk("R5", "sstore sum", int'(grant_o), 1);
        check_all();
        // R2: write without read is malformed
        apply(8'h05, 2'd0, 2'd1, 1'b0, 1'b0, 3'd0);
        chk("R2", "w without r", int'(invalid_o), 1);
        check_all();
        // R8: dirty/accessed corners
        apply(8'h47, 2'd1, 2'd1, 1'b0, 1'b0, 3'd3);
        chk("R8", "store sets D", int'(upd_attr_o), 8'hC7);
        check_all();
        apply(8'hC7, 2'd2, 2'd1, 1'b0, 1'b0, 3'd3);
        chk("R8", "no update", int'(upd_need_o), 0);
        check_all();
        apply(8'h47, 2'd0, 2'd1, 1'b0, 1'b0, 3'd3);
        chk("R8", "load no D", int'(upd_need_o), 0);
        check_all();
        // R7: machine and reserved privilege
        apply(8'hFB, 2'd0, 2'd3, 1'b1, 1'b1, 3'd0);
        chk("R7", "machine", int'(priv_err_o), 1);
        check_all();
        apply(8'hFB, 2'd3, 2'd2, 1'b1, 1'b1, 3'd0);
        chk("R7", "reserved", int'(grant_o), 0);
        check_all();
        // R10: update-disabled failure on rmw
        apply(8'h00, 2'd2, 2'd0, 1'b0, 1'b0, 3'd4);
        chk("R10", "rmw page", int'(cause_o), 15);
        check_all();

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            apply(r[7:0], r[9:8], r[11:10], r[12], r[13], r[16:14]);
            check_all();
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule